// File: doc/BRIEF.md
# External Interrupt Subclass Arbiter

This block keeps the pending state of five external-interrupt sources and, when asked to deliver, picks one under a fixed priority. The sources are an inter-processor emergency signal with a per-sender bitmap, an external call from one stored caller, a clock comparator, a CPU timer, and a service signal whose 32-bit parameters wait in an outside queue. Each source has its own enable bit, taken from a control register. A source competes only while it is both pending and enabled.

A delivery request is a single-cycle pulse. One cycle later the block presents the interruption code, the originating CPU address and the service parameter of the chosen source. In the same clock edge it clears the pending state of that source. The service queue is drained through a valid/pop handshake. A request made while the external mask is closed, or while nothing is eligible, does not deliver anything. It raises an error strobe and leaves all state unchanged. A combinational eligible-any output lets a higher-level arbiter see that some enabled source is waiting.

Top module: `ext_irq_arbiter`

## Requirements
- R1: Among eligible sources, delivery picks emergency first, then external call, then clock comparator, then CPU timer, then service.
- R2: Enable bit 0 gates emergency, bit 1 external call, bit 2 clock comparator, bit 3 CPU timer and bit 4 service. A source whose bit is 0 is never delivered and stays pending.
- R3: An emergency delivery has code 0x1201. It reports the lowest-numbered set bit of the sender bitmap as the CPU address and clears only that bit.
- R4: Emergency stays pending until the sender bitmap is all zero.
- R5: An external-call delivery has code 0x1202, reports the stored caller address and clears the external-call pending flag.
- R6: Clock-comparator (code 0x1004) and CPU-timer (code 0x1005) deliveries report CPU address 0 and clear only their own flag.
- R7: A service delivery has code 0x2401 and CPU address 0, outputs the queue head as the parameter, and pops exactly one entry in the cycle of the request. For every other source the parameter is 0.
- R8: A request with the external mask closed, or with no eligible source, raises the error strobe for one cycle without a valid strobe, and changes no pending state.
- R9: The eligible-any output is 1 exactly when some source is both pending and enabled.
- R10: After reset nothing is pending and both strobes are 0. Results appear on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mask_open | input | 1 | External interrupts are allowed |
| sub_en | input | 5 | Per-subclass enable bits (see R2) |
| emg_set | input | 1 | Record an emergency signal from a sender |
| emg_sender | input | 6 | Sender number for emg_set |
| xcall_set | input | 1 | Record an external call |
| xcall_addr | input | 16 | Caller address stored with xcall_set |
| ckc_set | input | 1 | Clock comparator condition |
| cpt_set | input | 1 | CPU timer condition |
| svc_valid | input | 1 | Service queue holds an entry |
| svc_param | input | 32 | Service queue head |
| svc_pop | output | 1 | Remove the queue head |
| deliver_req | input | 1 | Deliver one external interrupt |
| eligible_any | output | 1 | Some enabled source is pending |
| dlv_valid | output | 1 | A delivery result is present |
| dlv_error | output | 1 | The request could not be served |
| dlv_code | output | 16 | Interruption code |
| dlv_cpu_addr | output | 16 | Originating CPU address |
| dlv_param | output | 32 | External parameter |

## Verification
Senders 5 and 40 are placed in the bitmap together, and sender 63 is later placed in it alone. This separates a lowest-bit scan from a highest-bit scan or a whole-bitmap clear, and it tests the top index. All sources are set pending at once and then drained, which shows the full priority order. Runs with only some subclasses enabled separate gating from plain pending state. Requests with the mask closed, with nothing pending, and with an empty service queue show that an error leaves all state intact. Two queued service parameters show that each request pops exactly one entry.

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter #(
  parameter int NCPU = 64,
  parameter int AW   = 16,
  parameter int PW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_mask_open,
  input  logic [4:0]               sub_en,
  input  logic                     emg_set,
  input  logic [$clog2(NCPU)-1:0]  emg_sender,
  input  logic                     xcall_set,
  input  logic [AW-1:0]            xcall_addr,
  input  logic                     ckc_set,
  input  logic                     cpt_set,
  input  logic                     svc_valid,
  input  logic [PW-1:0]            svc_param,
  output logic                     svc_pop,
  input  logic                     deliver_req,
  output logic                     eligible_any,
  output logic                     dlv_valid,
  output logic                     dlv_error,
  output logic [15:0]              dlv_code,
  output logic [AW-1:0]            dlv_cpu_addr,
  output logic [PW-1:0]            dlv_param
);
  localparam int SW = $clog2(NCPU);
  localparam logic [15:0] C_EMG = 16'h1201;
  localparam logic [15:0] C_XC  = 16'h1202;
  localparam logic [15:0] C_CKC = 16'h1004;
  localparam logic [15:0] C_CPT = 16'h1005;
  localparam logic [15:0] C_SVC = 16'h2401;

  logic [NCPU-1:0] emg_map;
  logic            emg_pend, xc_pend, ckc_pend, cpt_pend;
  logic [AW-1:0]   xc_addr;
  logic [4:0]      elig, grant;
  logic [SW-1:0]   lo_idx;
  logic [NCPU-1:0] clr_bit, set_bit, map_left;
  logic            take;

  assign elig = {svc_valid & sub_en[4], cpt_pend & sub_en[3], ckc_pend & sub_en[2],
                 xc_pend & sub_en[1], emg_pend & sub_en[0]};
  assign grant        = elig & ~(elig - 5'd1);
  assign eligible_any = |elig;
  assign take         = deliver_req & ext_mask_open & eligible_any;
  assign svc_pop      = take & grant[4];

  always_comb begin
    lo_idx = '0;
    for (int i = NCPU - 1; i >= 0; i--)
      if (emg_map[i]) lo_idx = SW'(i);
  end

  assign clr_bit  = (take & grant[0]) ? (NCPU'(1) << lo_idx) : '0;
  assign set_bit  = emg_set ? (NCPU'(1) << emg_sender) : '0;
  assign map_left = emg_map & ~clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emg_map  <= '0;
      emg_pend <= 1'b0;
      xc_pend  <= 1'b0;
      ckc_pend <= 1'b0;
      cpt_pend <= 1'b0;
      xc_addr  <= '0;
    end else begin
      emg_map <= map_left | set_bit;
      if (emg_set) emg_pend <= 1'b1;
      else if (take && grant[0] && map_left == '0) emg_pend <= 1'b0;
      if (xcall_set) begin
        xc_pend <= 1'b1;
        xc_addr <= xcall_addr;
      end else if (take && grant[1]) xc_pend <= 1'b0;
      if (ckc_set) ckc_pend <= 1'b1;
      else if (take && grant[2]) ckc_pend <= 1'b0;
      if (cpt_set) cpt_pend <= 1'b1;
      else if (take && grant[3]) cpt_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid    <= 1'b0;
      dlv_error    <= 1'b0;
      dlv_code     <= '0;
      dlv_cpu_addr <= '0;
      dlv_param    <= '0;
    end else begin
      dlv_valid    <= take;
      dlv_error    <= deliver_req & ~take;
      dlv_code     <= '0;
      dlv_cpu_addr <= '0;
      dlv_param    <= '0;
      if (take) begin
        unique case (1'b1)
          grant[0]: begin dlv_code <= C_EMG; dlv_cpu_addr <= AW'(lo_idx); end
          grant[1]: begin dlv_code <= C_XC;  dlv_cpu_addr <= xc_addr; end
          grant[2]: dlv_code <= C_CKC;
          grant[3]: dlv_code <= C_CPT;
          default:  begin dlv_code <= C_SVC; dlv_param <= svc_param; end
        endcase
      end
    end
  end

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_emg_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant[0] && !emg_set |=> $countones(emg_map) == $countones($past(emg_map)) - 1);
  p_emg_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emg_pend == (|emg_map));
  p_timer_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && (dlv_code == C_CKC || dlv_code == C_CPT) |-> dlv_cpu_addr == '0);
  p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pop |-> svc_valid);
  p_err_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_req && !ext_mask_open |=> dlv_error && !dlv_valid);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dlv_valid && dlv_error));
endmodule

// File: tb/sim_ext_irq_arbiter.sv
`timescale 1ns/1ps
module sim_ext_irq_arbiter;
  logic clk = 0, rst_n = 0;
  logic ext_mask_open = 0;
  logic [4:0] sub_en = 0;
  logic emg_set = 0, xcall_set = 0, ckc_set = 0, cpt_set = 0, deliver_req = 0;
  logic [5:0] emg_sender = 0;
  logic [15:0] xcall_addr = 0;
  logic svc_valid = 0;
  logic [31:0] svc_param = 0;
  logic svc_pop, eligible_any, dlv_valid, dlv_error;
  logic [15:0] dlv_code, dlv_cpu_addr;
  logic [31:0] dlv_param;

  int checks = 0, errors = 0;
  logic [64:0] exp_q[$];
  string tag_q[$];
  logic [31:0] svcq[$];

  always #2 clk = ~clk;

  ext_irq_arbiter u0 (.clk, .rst_n, .ext_mask_open, .sub_en, .emg_set, .emg_sender,
    .xcall_set, .xcall_addr, .ckc_set, .cpt_set, .svc_valid, .svc_param, .svc_pop,
    .deliver_req, .eligible_any, .dlv_valid, .dlv_error, .dlv_code, .dlv_cpu_addr,
    .dlv_param);

  task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic svc_refresh();
    svc_valid = svcq.size() > 0;
    svc_param = svcq.size() > 0 ? svcq[0] : 32'h0;
  endtask

  // monitor: pop expected results and compare
  always @(negedge clk) begin
    if (rst_n && (dlv_valid || dlv_error)) begin
      logic [64:0] act;
      act = {dlv_error, dlv_code, dlv_cpu_addr, dlv_param};
      if (exp_q.size() == 0) check(0, "R10 unexpected result", act, 65'h0);
      else begin
        logic [64:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act === e && !(dlv_valid && dlv_error), t, act, e);
      end
    end
  end

  // driver: push expectation, pulse request
  task automatic deliver(bit err, logic [15:0] code, logic [15:0] addr,
                         logic [31:0] prm, string tag);
    bit pop_now;
    @(negedge clk);
    exp_q.push_back({err, code, addr, prm});
    tag_q.push_back(tag);
    deliver_req = 1;
    #1 pop_now = svc_pop;
    @(negedge clk);
    deliver_req = 0;
    if (pop_now) begin
      void'(svcq.pop_front());
      svc_refresh();
    end
  endtask

  task automatic set_emg(int id);
    @(negedge clk); emg_set = 1; emg_sender = 6'(id);
    @(negedge clk); emg_set = 0;
  endtask

  task automatic pulse_misc(bit xc, logic [15:0] a, bit ck, bit ct);
    @(negedge clk); xcall_set = xc; xcall_addr = a; ckc_set = ck; cpt_set = ct;
    @(negedge clk); xcall_set = 0; ckc_set = 0; cpt_set = 0;
  endtask

  task automatic chk_elig(bit exp, string tag);
    @(negedge clk);
    check(eligible_any === exp, tag, 65'(eligible_any), 65'(exp));
  endtask

  initial begin
    #(4 * 100000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!dlv_valid && !dlv_error && !eligible_any && !svc_pop, "R10 reset state",
          {dlv_valid, dlv_error, eligible_any, svc_pop}, 0);
    sub_en = 5'h1F; ext_mask_open = 1;
    deliver(1, 0, 0, 0, "R8 nothing eligible");

    // all sources pending, drain in priority order
    set_emg(40); set_emg(5);
    pulse_misc(1, 16'h0123, 1, 1);
    svcq.push_back(32'hDEADBEEF); svcq.push_back(32'h12345678); svc_refresh();
    chk_elig(1, "R9 eligible with pending");
    deliver(0, 16'h1201, 16'd5, 0, "R1 R3 emergency lowest sender 5");
    sub_en = 5'b00001;
    chk_elig(1, "R4 emergency still pending after one of two");
    deliver(0, 16'h1201, 16'd40, 0, "R3 emergency sender 40");
    chk_elig(0, "R4 emergency cleared with empty bitmap");
    sub_en = 5'h1F;
    deliver(0, 16'h1202, 16'h0123, 0, "R1 R5 external call");
    deliver(0, 16'h1004, 0, 0, "R1 R6 clock comparator");
    deliver(0, 16'h1005, 0, 0, "R1 R6 cpu timer");
    deliver(0, 16'h2401, 0, 32'hDEADBEEF, "R1 R7 service first");
    deliver(0, 16'h2401, 0, 32'h12345678, "R7 service second");
    deliver(1, 0, 0, 0, "R8 service queue empty");

    // enables
    pulse_misc(0, 0, 1, 1);
    sub_en = 5'b01000;
    deliver(0, 16'h1005, 0, 0, "R2 only cpu timer enabled");
    sub_en = 5'b0;
    chk_elig(0, "R9 nothing enabled");
    deliver(1, 0, 0, 0, "R2 disabled clock comparator not delivered");
    sub_en = 5'b00100;
    deliver(0, 16'h1004, 0, 0, "R2 clock comparator kept pending");

    // mask closed
    sub_en = 5'h1F;
    set_emg(63);
    ext_mask_open = 0;
    deliver(1, 0, 0, 0, "R8 mask closed");
    ext_mask_open = 1;
    chk_elig(1, "R8 state unchanged after error");
    deliver(0, 16'h1201, 16'd63, 0, "R3 emergency top sender");
    chk_elig(0, "R9 all drained");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all results seen", 65'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule